// File: doc/BRIEF.md
# Cartridge Program and Pattern Bank Mapper

This block is the address logic of a simple game cartridge for a 6502-based console. It watches the CPU address, data, read/write and M2 strobe lines. From them it produces the chip selects, output enables and upper address lines for two program ROMs. A 32K fixed ROM answers reads in the upper half of the address space. A second ROM answers reads in the 8K window at $6000-$7FFF, and latched register bits pick which 8K slice of it is visible.

Three one-bit latches sit in the expansion area near $4020. Their addresses are compared only on the bits of mask $EC7F, so each latch also answers at every mirror address. Strap inputs stand in for the board jumpers. One strap widens the window ROM to 32K by adding a second bank bit. One strap picks which latch drives the pattern-memory bank line. One strap connects a latch bit to the active-low interrupt output.

Writes to the window-bank latch take place while the ROM also drives the bus, so the value stored is the AND of the two. The block models this with a separate input that carries the ROM's drive value. All state is clocked by a system clock, and the clock samples the CPU strobes.

Top module: `cart_bank_mapper`

## Requirements
- R1: After a synchronous active-low reset, all three latches hold 0. Therefore `chr_bank` is 0, `irq_n` is 1, and `prg1_addr[14:13]` is 0.
- R2: A read (`cpu_rw`=1, `m2`=1) with `cpu_addr[15]`=1 drives `prg0_ce_n` and `prg0_oe_n` low, with `prg0_addr` equal to `cpu_addr[14:0]`.
- R3: A read with `cpu_addr[15:13]`=3'b011 drives `prg1_ce_n` and `prg1_oe_n` low. `prg1_addr[12:0]` equals `cpu_addr[12:0]`, and `prg1_addr[13]` equals the window latch (bit 0 of the last write to $4027).
- R4: With `strap_wide`=1, `prg1_addr[14]` equals the high latch (bit 0 of the last write to $4020). With `strap_wide`=0 it is 0.
- R5: A write matches a latch when (`cpu_addr` & 16'hEC7F) equals (latch address & 16'hEC7F). Address bits 7, 8, 9 and 12 are ignored, and a write that differs in any other bit leaves the latch unchanged.
- R6: A latch captures only on a clock edge with `cpu_rw`=0 and `m2`=1. Reads, and writes with `m2`=0, leave every latch unchanged.
- R7: `chr_bank` equals the window latch when `strap_chr_src`=0, and the high latch when `strap_chr_src`=1.
- R8: With `strap_irq_en`=1, `irq_n` is the inverse of the IRQ latch (bit 1 of the last write to $4022). With `strap_irq_en`=0, `irq_n` is 1.
- R9: The window latch stores `cpu_data[0] & rom_data[0]`. The high latch and the IRQ latch store CPU data only, whatever `rom_data` holds.
- R10: No chip select or output enable is low during a write, while `m2` is 0, or for an address below $6000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the CPU strobes |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | Data driven by the CPU on writes |
| rom_data | input | 8 | Data the selected ROM drives during a conflicting write |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| m2 | input | 1 | CPU phase-2 strobe, high while the bus is valid |
| strap_wide | input | 1 | 1 = window ROM is 32K and the high latch drives its bit 14 |
| strap_chr_src | input | 1 | Source of the pattern bank line: 0 = window latch, 1 = high latch |
| strap_irq_en | input | 1 | 1 = IRQ latch drives `irq_n` |
| prg0_ce_n | output | 1 | Fixed ROM chip select, active low |
| prg0_oe_n | output | 1 | Fixed ROM output enable, active low |
| prg0_addr | output | 15 | Fixed ROM address |
| prg1_ce_n | output | 1 | Window ROM chip select, active low |
| prg1_oe_n | output | 1 | Window ROM output enable, active low |
| prg1_addr | output | 15 | Window ROM address |
| chr_bank | output | 1 | Pattern memory bank line |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The bench builds the block with its default parameters. These are a 16-bit address, mask $EC7F, latch addresses $4027, $4020 and $4022, and the bus-conflict model enabled. With these settings the real mirror set is reachable: the bench ORs random combinations of bits 7, 8, 9 and 12 into the latch addresses, and flips other mask bits to produce near-miss addresses. Because the conflict model is on, random `rom_data` values test the AND on the window latch, and the other two latches show that they ignore that input. The straps change at random between operations, so every routing of the bank and interrupt lines is seen with every latch state.

// File: rtl/cart_map_pkg.sv
// Package: shared types for the cartridge bank mapper.
// Assumes: one load strobe per latch, at most one active at a time.
package cart_map_pkg;

    // One load strobe per bank latch, produced by the register decoder.
    typedef struct packed {
        logic win;   // window bank latch
        logic hi;    // high window bank latch
        logic irq;   // interrupt latch
    } reg_hit_t;

endpackage

// File: rtl/cart_reg_decode.sv
// Module: cart_reg_decode
// Compares a CPU write against three latch addresses under a partial mask.
// Address bits that are clear in MASK are ignored, which creates mirrors.
// Assumes: a write is cpu_rw low while m2 is high; the latch addresses
// differ from one another in at least one masked bit.
module cart_reg_decode
    import cart_map_pkg::*;
#(
    parameter int              AW       = 16,
    parameter logic [AW-1:0]   MASK     = 16'hEC7F,
    parameter logic [AW-1:0]   ADDR_WIN = 16'h4027,
    parameter logic [AW-1:0]   ADDR_HI  = 16'h4020,
    parameter logic [AW-1:0]   ADDR_IRQ = 16'h4022
) (
    input  logic [AW-1:0] cpu_addr,
    input  logic          cpu_rw,
    input  logic          m2,
    output reg_hit_t      hit
);

    localparam logic [AW-1:0] KEY_WIN = ADDR_WIN & MASK;
    localparam logic [AW-1:0] KEY_HI  = ADDR_HI  & MASK;
    localparam logic [AW-1:0] KEY_IRQ = ADDR_IRQ & MASK;

    logic          wr_phase;
    logic [AW-1:0] key;

    // Qualify the bus cycle as a valid write and strip the ignored bits.
    always_comb begin
        wr_phase = m2 && !cpu_rw;
        key      = cpu_addr & MASK;
    end

    // One load strobe per latch.
    always_comb begin
        hit.win = wr_phase && (key == KEY_WIN);
        hit.hi  = wr_phase && (key == KEY_HI);
        hit.irq = wr_phase && (key == KEY_IRQ);
    end

endmodule

// File: rtl/cart_bank_latch.sv
// Module: cart_bank_latch
// A W-bit storage latch with a synchronous active-low clear and a load enable.
// Assumes: load is a single-cycle or held strobe sampled on the clock edge.
module cart_bank_latch #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Clear on reset, otherwise take d when loaded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/cart_prg_select.sv
// Module: cart_prg_select
// Chip selects, output enables and address lines for the two program ROMs.
// Assumes: the fixed ROM fills the upper half of the address space, and the
// window ROM occupies the 8K slice just below it.
module cart_prg_select #(
    parameter int AW = 16
) (
    input  logic          cpu_rw,
    input  logic          m2,
    input  logic [AW-1:0] cpu_addr,
    input  logic          win_bit,
    input  logic          hi_bit,
    input  logic          strap_wide,
    output logic          prg0_ce_n,
    output logic          prg0_oe_n,
    output logic [AW-2:0] prg0_addr,
    output logic          prg1_ce_n,
    output logic          prg1_oe_n,
    output logic [AW-2:0] prg1_addr
);

    localparam int LOW_W = AW - 3;   // address bits inside one 8K slice

    logic rd_phase;
    logic fix_sel;
    logic win_sel;

    // Region decode, qualified by a read with m2 high.
    always_comb begin
        rd_phase = m2 && cpu_rw;
        fix_sel  = rd_phase && cpu_addr[AW-1];
        win_sel  = rd_phase && (cpu_addr[AW-1:AW-3] == 3'b011);
    end

    // Active-low strobes for both ROMs.
    always_comb begin
        prg0_ce_n = !fix_sel;
        prg0_oe_n = !fix_sel;
        prg1_ce_n = !win_sel;
        prg1_oe_n = !win_sel;
    end

    // Fixed ROM address passes straight through; window ROM gets bank bits on top.
    always_comb begin
        prg0_addr = cpu_addr[AW-2:0];
        prg1_addr = {(strap_wide & hi_bit), win_bit, cpu_addr[LOW_W-1:0]};
    end

endmodule

// File: rtl/cart_line_route.sv
// Module: cart_line_route
// Routes latch bits to the pattern bank line and the interrupt output,
// following the strap inputs.
// Assumes: straps are static in use, but any change takes effect at once.
module cart_line_route (
    input  logic win_bit,
    input  logic hi_bit,
    input  logic irq_bit,
    input  logic strap_chr_src,
    input  logic strap_irq_en,
    output logic chr_bank,
    output logic irq_n
);

    // Pick the bank source, and gate the interrupt latch onto an active-low pin.
    always_comb begin
        chr_bank = strap_chr_src ? hi_bit : win_bit;
        irq_n    = strap_irq_en ? !irq_bit : 1'b1;
    end

endmodule

// File: rtl/cart_bank_mapper.sv
// Module: cart_bank_mapper (top)
// Cartridge mapper: one fixed 32K program ROM, one banked 8K window,
// three mirrored write-only latches, strap-selected routing, and a
// bus-conflict AND on the window latch.
// Assumes: clk is fast enough to sample every m2-high phase at least once.
module cart_bank_mapper
    import cart_map_pkg::*;
#(
    parameter int              AW          = 16,
    parameter int              DW          = 8,
    parameter logic [AW-1:0]   REG_MASK    = 16'hEC7F,
    parameter logic [AW-1:0]   ADDR_WIN    = 16'h4027,
    parameter logic [AW-1:0]   ADDR_HI     = 16'h4020,
    parameter logic [AW-1:0]   ADDR_IRQ    = 16'h4022,
    parameter int              WIN_BIT     = 0,
    parameter int              HI_BIT      = 0,
    parameter int              IRQ_BIT     = 1,
    parameter bit              CONFLICT_EN = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_data,
    input  logic [DW-1:0] rom_data,
    input  logic          cpu_rw,
    input  logic          m2,
    input  logic          strap_wide,
    input  logic          strap_chr_src,
    input  logic          strap_irq_en,
    output logic          prg0_ce_n,
    output logic          prg0_oe_n,
    output logic [AW-2:0] prg0_addr,
    output logic          prg1_ce_n,
    output logic          prg1_oe_n,
    output logic [AW-2:0] prg1_addr,
    output logic          chr_bank,
    output logic          irq_n
);

    reg_hit_t hit;
    logic     win_d;
    logic     win_q;
    logic     hi_q;
    logic     irq_q;
    logic     unused_bus_bits;

    // Data bits not selected by the bit parameters carry no function.
    assign unused_bus_bits = ^{cpu_data, rom_data};

    cart_reg_decode #(
        .AW       (AW),
        .MASK     (REG_MASK),
        .ADDR_WIN (ADDR_WIN),
        .ADDR_HI  (ADDR_HI),
        .ADDR_IRQ (ADDR_IRQ)
    ) u_decode (
        .cpu_addr (cpu_addr),
        .cpu_rw   (cpu_rw),
        .m2       (m2),
        .hit      (hit)
    );

    // The window latch sees the wired AND of the CPU and ROM drivers when the
    // conflict model is enabled.
    generate
        if (CONFLICT_EN) begin : g_conflict
            assign win_d = cpu_data[WIN_BIT] & rom_data[WIN_BIT];
        end else begin : g_clean
            assign win_d = cpu_data[WIN_BIT];
        end
    endgenerate

    cart_bank_latch #(.W(1)) u_win_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (hit.win),
        .d     (win_d),
        .q     (win_q)
    );

    cart_bank_latch #(.W(1)) u_hi_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (hit.hi),
        .d     (cpu_data[HI_BIT]),
        .q     (hi_q)
    );

    cart_bank_latch #(.W(1)) u_irq_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (hit.irq),
        .d     (cpu_data[IRQ_BIT]),
        .q     (irq_q)
    );

    cart_prg_select #(.AW(AW)) u_prg (
        .cpu_rw     (cpu_rw),
        .m2         (m2),
        .cpu_addr   (cpu_addr),
        .win_bit    (win_q),
        .hi_bit     (hi_q),
        .strap_wide (strap_wide),
        .prg0_ce_n  (prg0_ce_n),
        .prg0_oe_n  (prg0_oe_n),
        .prg0_addr  (prg0_addr),
        .prg1_ce_n  (prg1_ce_n),
        .prg1_oe_n  (prg1_oe_n),
        .prg1_addr  (prg1_addr)
    );

    cart_line_route u_route (
        .win_bit       (win_q),
        .hi_bit        (hi_q),
        .irq_bit       (irq_q),
        .strap_chr_src (strap_chr_src),
        .strap_irq_en  (strap_irq_en),
        .chr_bank      (chr_bank),
        .irq_n         (irq_n)
    );

endmodule

// File: rtl/cart_bank_mapper_chk.sv
// Module: cart_bank_mapper_chk
// Port-level properties of the mapper, bound into every instance.
// Assumes: the default 16-bit address and 8-bit data widths.
module cart_bank_mapper_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] cpu_addr,
    input logic [7:0]  cpu_data,
    input logic [7:0]  rom_data,
    input logic        cpu_rw,
    input logic        m2,
    input logic        strap_wide,
    input logic        strap_chr_src,
    input logic        strap_irq_en,
    input logic        prg0_ce_n,
    input logic        prg0_oe_n,
    input logic        prg1_ce_n,
    input logic        prg1_oe_n,
    input logic [14:0] prg1_addr,
    input logic        chr_bank,
    input logic        irq_n
);

    logic wr_to_win;

    // Independent match on the window latch address under the mirror mask.
    assign wr_to_win = !cpu_rw && m2 && ((cpu_addr & 16'hEC7F) == 16'h4027);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!chr_bank && irq_n && (prg1_addr[14:13] == 2'b00)));  // R1

    AST_NO_SELECT_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_rw || !m2) |-> (prg0_ce_n && prg0_oe_n && prg1_ce_n && prg1_oe_n));  // R10

    AST_ONE_ROM_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!prg0_ce_n, !prg1_ce_n}));  // R3

    AST_LOW_REGION_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr < 16'h6000) |-> (prg0_ce_n && prg1_ce_n));  // R10

    AST_FIXED_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rw && m2 && cpu_addr[15]) |-> (!prg0_ce_n && !prg0_oe_n));  // R2

    AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ((cpu_rw || !m2) ##1 ($stable(strap_chr_src) && $stable(strap_irq_en)))
        |-> ($stable(chr_bank) && $stable(irq_n)));  // R6

    AST_IRQ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !strap_irq_en |-> irq_n);  // R8

    AST_CONFLICT_AND: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_to_win && !(cpu_data[0] && rom_data[0])) ##1 !strap_chr_src)
        |-> !chr_bank);  // R9

    AST_NARROW_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        !strap_wide |-> !prg1_addr[14]);  // R4

endmodule

bind cart_bank_mapper cart_bank_mapper_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_addr      (cpu_addr),
    .cpu_data      (cpu_data),
    .rom_data      (rom_data),
    .cpu_rw        (cpu_rw),
    .m2            (m2),
    .strap_wide    (strap_wide),
    .strap_chr_src (strap_chr_src),
    .strap_irq_en  (strap_irq_en),
    .prg0_ce_n     (prg0_ce_n),
    .prg0_oe_n     (prg0_oe_n),
    .prg1_ce_n     (prg1_ce_n),
    .prg1_oe_n     (prg1_oe_n),
    .prg1_addr     (prg1_addr),
    .chr_bank      (chr_bank),
    .irq_n         (irq_n)
);

// File: tb/test_cart_bank_mapper.sv
// Bench: directed corner cases followed by seeded random traffic, compared
// against a reference model written from the requirements.
module test_cart_bank_mapper;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_data = 8'h00;
    logic [7:0]  rom_data = 8'h00;
    logic        cpu_rw = 1'b1;
    logic        m2 = 1'b0;
    logic        strap_wide = 1'b0;
    logic        strap_chr_src = 1'b0;
    logic        strap_irq_en = 1'b0;
    logic        prg0_ce_n, prg0_oe_n, prg1_ce_n, prg1_oe_n;
    logic [14:0] prg0_addr, prg1_addr;
    logic        chr_bank, irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference latch state.
    bit m_win = 1'b0;
    bit m_hi  = 1'b0;
    bit m_irq = 1'b0;

    always #10 clk = !clk;   // 50 MHz

    cart_bank_mapper i_cart_bank_mapper (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .rom_data(rom_data), .cpu_rw(cpu_rw), .m2(m2), .strap_wide(strap_wide),
        .strap_chr_src(strap_chr_src), .strap_irq_en(strap_irq_en),
        .prg0_ce_n(prg0_ce_n), .prg0_oe_n(prg0_oe_n), .prg0_addr(prg0_addr),
        .prg1_ce_n(prg1_ce_n), .prg1_oe_n(prg1_oe_n), .prg1_addr(prg1_addr),
        .chr_bank(chr_bank), .irq_n(irq_n)
    );

    function automatic bit hits(input logic [15:0] a, input logic [15:0] r);
        return (a & 16'hEC7F) == (r & 16'hEC7F);
    endfunction

    function automatic bit exp_chr();
        return strap_chr_src ? m_hi : m_win;
    endfunction

    function automatic bit exp_irq_n();
        return strap_irq_en ? !m_irq : 1'b1;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // A CPU write cycle; 'strobe' = 0 drives the write with m2 held low.
    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d,
                             input logic [7:0] r, input bit strobe);
        @(negedge clk);
        cpu_addr = a; cpu_data = d; rom_data = r; cpu_rw = 1'b0; m2 = strobe;
        #2;
        check("R10 select during write", {prg0_ce_n, prg0_oe_n, prg1_ce_n, prg1_oe_n}, 4'hF);
        @(posedge clk);
        @(negedge clk);
        m2 = 1'b0; cpu_rw = 1'b1;
        if (strobe) begin
            if (hits(a, 16'h4027)) m_win = d[0] & r[0];
            if (hits(a, 16'h4020)) m_hi  = d[0];
            if (hits(a, 16'h4022)) m_irq = d[1];
        end
    endtask

    // A CPU read cycle that checks every output against the model.
    task automatic cpu_read_check(input logic [15:0] a, input string tag);
        bit fx, wn;
        @(negedge clk);
        cpu_addr = a; cpu_rw = 1'b1; m2 = 1'b1;
        #2;
        fx = a[15];
        wn = (a[15:13] == 3'b011);
        check({tag, " R2 fixed select"}, {prg0_ce_n, prg0_oe_n}, {!fx, !fx});
        check({tag, " R3 window select"}, {prg1_ce_n, prg1_oe_n}, {!wn, !wn});
        if (fx) check({tag, " R2 fixed address"}, prg0_addr, a[14:0]);
        if (wn) check({tag, " R3/R4 window address"}, prg1_addr,
                      {(strap_wide & m_hi), m_win, a[12:0]});
        check({tag, " R7 chr bank"}, chr_bank, exp_chr());
        check({tag, " R8 irq"}, irq_n, exp_irq_n());
        @(negedge clk);
        m2 = 1'b0;
        #2;
        check({tag, " R10 idle select"}, {prg0_ce_n, prg1_ce_n}, 2'b11);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        strap_wide = 1'b1; strap_irq_en = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 chr after reset", chr_bank, 1'b0);
        check("R1 irq after reset", irq_n, 1'b1);
        rst_n = 1'b1;
        cpu_read_check(16'h6123, "R1 window bits after reset");

        // R3 R7: plain write to the window latch, no conflict
        cpu_write(16'h4027, 8'h01, 8'hFF, 1'b1);
        cpu_read_check(16'h7ABC, "R3 window set");
        // R5: mirror with bits 7 and 12 set clears it
        cpu_write(16'h50A7, 8'h00, 8'hFF, 1'b1);
        cpu_read_check(16'h6000, "R5 mirror clear");
        cpu_write(16'h4027, 8'h01, 8'hFF, 1'b1);
        // R5: bit 10 differs, must miss
        cpu_write(16'h4427, 8'h00, 8'hFF, 1'b1);
        cpu_read_check(16'h6001, "R5 near miss");
        // R9: conflict, ROM drives 0 on bit 0
        cpu_write(16'h4027, 8'h01, 8'hFE, 1'b1);
        cpu_read_check(16'h6002, "R9 conflict AND");
        // R9 R4: high latch ignores rom_data
        cpu_write(16'h4320, 8'h01, 8'h00, 1'b1);
        cpu_read_check(16'h7FFF, "R9 R4 high latch");
        strap_wide = 1'b0;
        cpu_read_check(16'h7FFF, "R4 narrow window");
        strap_chr_src = 1'b1;
        cpu_read_check(16'hFFFC, "R7 chr from high latch");
        // R6: write with m2 low has no effect
        cpu_write(16'h4020, 8'h00, 8'h00, 1'b0);
        cpu_read_check(16'h8000, "R6 m2 low write");
        // R6: a read at the latch address leaves it
        cpu_read_check(16'h4020, "R6 read at latch");
        // R8: IRQ set and clear
        cpu_write(16'h4222, 8'h02, 8'h00, 1'b1);
        cpu_read_check(16'h9000, "R8 irq set");
        strap_irq_en = 1'b0;
        cpu_read_check(16'h9000, "R8 irq strap off");
        strap_irq_en = 1'b1;
        cpu_write(16'h4022, 8'hFD, 8'h00, 1'b1);
        cpu_read_check(16'h9000, "R8 irq clear");
        // R10: reads below the window select nothing
        cpu_read_check(16'h5FFF, "R10 below window");

        // Random traffic
        for (int i = 0; i < 600; i++) begin
            logic [15:0] base, a;
            int pick;
            pick = $urandom_range(0, 3);
            base = (pick == 0) ? 16'h4027 : (pick == 1) ? 16'h4020 :
                   (pick == 2) ? 16'h4022 : 16'($urandom);
            a = base | (16'($urandom) & 16'h1380);
            if ($urandom_range(0, 4) == 0) a = a ^ (16'h0001 << $urandom_range(10, 15));
            strap_wide    = 1'($urandom);
            strap_chr_src = 1'($urandom);
            strap_irq_en  = 1'($urandom);
            cpu_write(a, 8'($urandom), 8'($urandom), ($urandom_range(0, 5) != 0));
            cpu_read_check(16'($urandom), "R5 R9 random");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule